// File: doc/BRIEF.md
# Channel-Status and User-Bit Block Capture

This block sits behind a two-channel digital audio line decoder. Each subframe that the decoder recovers is handed over as one strobe. The strobe carries the channel index, the subframe's channel-status bit and its user bit, and a flag marking the first frame of a 192-frame block. The block gathers these bits into per-channel 192-bit arrays, one for channel status and one for user data. When a whole block has been gathered, it commits the arrays to a readable copy in one step.

Software reads the committed arrays as 32-bit words through an offset-addressed read port. The block also keeps a latched event register with a set/clear interrupt mask. When a block completes, it raises a block-end event, and it raises a per-channel change event if that channel's channel-status content differs from the copy already held. Events from the line decoder (ready, lock, loss, parity, overrun, preamble) enter through a vector and are latched at their fixed bit positions.

Top module: `cs_user_capture`

## Requirements
- R1: After reset the status register, the mask register, the pending view and every status/user word read as zero, and `irq_o` is low.
- R2: Frame f of a block (frame 0 carries the start flag) of channel c puts its channel-status bit at bit f%32 of the word at offset 0x30 + c*0x30 + (f/32)*4, and its user bit at the same bit of offset 0x48 + c*0x30 + (f/32)*4. The earliest frames therefore land in the low byte.
- R3: The readable words keep the previous block's content while a block is being gathered, and change only at the edge that takes the channel-1 subframe of frame 191.
- R4: Completing a 192-frame block sets status bit 3 (block end) exactly once, visible on the first read after the final strobe.
- R5: At block end, status bit 8+c is set only if channel c's new channel-status array differs from the committed one. Differences in user bits alone never set these bits.
- R6: A strobe on channel 0 with the start flag set sets status bit 11 and restarts gathering at frame 0. The partial block is dropped: no block-end event and no change to the readable words.
- R7: Until the first start flag after reset, strobes are not captured and cannot complete a block.
- R8: Bits 0, 1, 2, 5, 6 and 13 of `ext_evt_i` latch into the same status bits. Its other bit positions have no effect.
- R9: Writing offset 0x08 sets the mask bits that are 1 in the data, and writing offset 0x0C clears them. The mask reads back at offset 0x04.
- R10: A read of offset 0x00 returns the latched status and clears it. An event arriving in the same cycle stays latched. Offset 0x10 returns status AND mask without clearing, and `irq_o` is high exactly when that value is non-zero.
- R11: Reads of any other offset, including misaligned ones, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld_i | input | 1 | One subframe's bits are present this cycle |
| bit_ch_i | input | 1 | Channel index of the subframe (0 or 1) |
| cs_bit_i | input | 1 | Channel-status bit of the subframe |
| ud_bit_i | input | 1 | User bit of the subframe |
| blk_start_i | input | 1 | First frame of a block (honoured with channel 0) |
| ext_evt_i | input | 15 | Event pulses from the line decoder |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte offset |
| wr_data_i | input | 15 | Register write data (mask bits) |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read byte offset |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Any pending (status AND mask) bit set |

## Verification
The hardest condition to reach is a start flag that lands in the middle of a block, because a plain stream of complete blocks never produces it. The bench sends fifty frames of a new pattern behind a start flag and then issues a second start. It confirms that no block-end event appeared and that the readable words still hold the block before. A second hard case is a read that clears the status in the same cycle as a new event. The bench lines up the read strobe and an external event pulse on the same clock edge.

// File: rtl/csu_pkg.sv
// Package for the channel-status/user-bit capture block.
// Holds the interrupt bit positions, the register offsets that software
// decodes, and the fixed channel count. Assumes two audio channels.
package csu_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_W   = 1;
    localparam int IRQ_W  = 15;

    localparam int IB_READY   = 0;
    localparam int IB_LOCKED  = 1;
    localparam int IB_LOSS    = 2;
    localparam int IB_BLKEND  = 3;
    localparam int IB_PARERR  = 5;
    localparam int IB_OVERRUN = 6;
    localparam int IB_CSC0    = 8;
    localparam int IB_BLKST   = 11;
    localparam int IB_PREERR  = 13;

    localparam logic [IRQ_W-1:0] EXT_MASK =
        IRQ_W'((1 << IB_READY) | (1 << IB_LOCKED) | (1 << IB_LOSS) |
               (1 << IB_PARERR) | (1 << IB_OVERRUN) | (1 << IB_PREERR));

    localparam int OFS_STATUS = 'h00;
    localparam int OFS_MASK   = 'h04;
    localparam int OFS_IEN    = 'h08;
    localparam int OFS_IDIS   = 'h0C;
    localparam int OFS_PEND   = 'h10;
endpackage

// File: rtl/csu_collect.sv
// Gathers one channel-status bit and one user bit per subframe into
// shadow arrays, then commits them to the readable copy when the
// channel-1 subframe of the last frame arrives. It produces block-end,
// block-start and per-channel status-change events.
// Assumes the start flag accompanies the channel-0 subframe of frame 0
// and that each frame presents channel 0 before channel 1.
module csu_collect
    import csu_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_vld_i,
    input  logic [CH_W-1:0]                bit_ch_i,
    input  logic                           cs_bit_i,
    input  logic                           ud_bit_i,
    input  logic                           blk_start_i,
    output logic [NUM_CH-1:0][FRAMES-1:0]  cs_live_o,
    output logic [NUM_CH-1:0][FRAMES-1:0]  ud_live_o,
    output logic                           blk_end_o,
    output logic                           blk_st_o,
    output logic [NUM_CH-1:0]              csc_o
);
    localparam int FCW = $clog2(FRAMES);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
    localparam logic [FCW-1:0]  LAST_FR = FCW'(FRAMES - 1);

    logic [NUM_CH-1:0][FRAMES-1:0] cs_sh_q, cs_sh_d, ud_sh_q, ud_sh_d;
    logic [NUM_CH-1:0][FRAMES-1:0] cs_live_q, ud_live_q;
    logic [FCW-1:0]                frame_q, idx;
    logic                          synced_q, restart, accept, last;

    // Decide whether this strobe is taken, where it lands, and whether it closes a block.
    always_comb begin
        restart = bit_vld_i && blk_start_i && (bit_ch_i == '0);
        accept  = bit_vld_i && (synced_q || restart);
        idx     = restart ? '0 : frame_q;
        cs_sh_d = cs_sh_q;
        ud_sh_d = ud_sh_q;
        if (accept) begin
            cs_sh_d[bit_ch_i][idx] = cs_bit_i;
            ud_sh_d[bit_ch_i][idx] = ud_bit_i;
        end
        last = accept && (bit_ch_i == LAST_CH) && (idx == LAST_FR);
    end

    // Per-channel compare of the finished status block against the committed one.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            csc_o[c] = last && (cs_sh_d[c] != cs_live_q[c]);
        end
    end

    // Shadow capture, frame counting and block commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sh_q   <= '0;
            ud_sh_q   <= '0;
            cs_live_q <= '0;
            ud_live_q <= '0;
            frame_q   <= '0;
            synced_q  <= 1'b0;
        end else begin
            cs_sh_q <= cs_sh_d;
            ud_sh_q <= ud_sh_d;
            if (restart) begin
                synced_q <= 1'b1;
            end
            if (accept) begin
                frame_q <= (bit_ch_i == LAST_CH) ?
                           ((idx == LAST_FR) ? '0 : idx + 1'b1) : idx;
            end
            if (last) begin
                cs_live_q <= cs_sh_d;
                ud_live_q <= ud_sh_d;
            end
        end
    end

    assign cs_live_o = cs_live_q;
    assign ud_live_o = ud_live_q;
    assign blk_end_o = last;
    assign blk_st_o  = restart;

    // R3: the readable copy moves only on a block end
    assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_end_o |=> ($stable(cs_live_q) && $stable(ud_live_q)));

    // R4: after a block end the next strobe lands at frame 0
    assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end_o |=> (frame_q == '0));

    // R7: before the first start flag nothing is captured
    assert_idle_until_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!synced_q && !restart) |=> ((frame_q == '0) && $stable(cs_sh_q) && $stable(ud_sh_q)));

    // R2: the frame counter never leaves the block
    assert_frame_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q <= LAST_FR);
endmodule

// File: rtl/csu_irq.sv
// Latched event register with a set/clear mask. Events set status bits.
// Reading the status offset clears all bits, but an event in the same
// cycle survives. The mask is changed by write-one-to-set and
// write-one-to-clear offsets. Assumes a single register access per cycle.
module csu_irq
    import csu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_W-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [IRQ_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [IRQ_W-1:0]  status_o,
    output logic [IRQ_W-1:0]  mask_o,
    output logic              irq_o
);
    logic [IRQ_W-1:0] status_q, mask_q;
    logic             rd_clr, wr_set, wr_clr;

    // Decode the accesses that touch this register set.
    always_comb begin
        rd_clr = rd_en_i && (rd_addr_i == ADDR_W'(OFS_STATUS));
        wr_set = wr_en_i && (wr_addr_i == ADDR_W'(OFS_IEN));
        wr_clr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_IDIS));
    end

    // Latch events, clear on status read, update the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (rd_clr ? '0 : status_q) | evt_i;
            if (wr_set) begin
                mask_q <= mask_q | wr_data_i;
            end else if (wr_clr) begin
                mask_q <= mask_q & ~wr_data_i;
            end
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & mask_q);

    // R8: every event pulse is latched
    assert_evt_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    // R10: a status read with no new event leaves status empty
    assert_rd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (evt_i == '0)) |=> (status_q == '0));

    // R9: enable write sets the written mask bits
    assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

    // R9: disable write clears the written mask bits
    assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(wr_data_i)) == '0));
endmodule

// File: rtl/csu_rdport.sv
// Offset-addressed read port with one cycle of latency. Serves the
// status (clear side effect handled in csu_irq), mask and pending views,
// and the committed status/user words. The channel stride and the user
// offset inside a stride are parameters. Unmapped offsets read zero.
// Assumes FRAMES is a multiple of WORD_W.
module csu_rdport
    import csu_pkg::*;
#(
    parameter int FRAMES    = 192,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CS_BASE   = 'h30,
    parameter int CH_STRIDE = 'h30,
    parameter int UD_REL    = 'h18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    input  logic [IRQ_W-1:0]              status_i,
    input  logic [IRQ_W-1:0]              mask_i,
    input  logic [NUM_CH-1:0][FRAMES-1:0] cs_live_i,
    input  logic [NUM_CH-1:0][FRAMES-1:0] ud_live_i,
    output logic [WORD_W-1:0]             rd_data_o
);
    localparam int WORDS = FRAMES / WORD_W;
    localparam int BYTES = WORD_W / 8;

    logic [WORD_W-1:0] rd_val, rd_q;

    // Select the word addressed by the read offset.
    always_comb begin
        rd_val = '0;
        if (rd_addr_i == ADDR_W'(OFS_STATUS)) rd_val = WORD_W'(status_i);
        if (rd_addr_i == ADDR_W'(OFS_MASK))   rd_val = WORD_W'(mask_i);
        if (rd_addr_i == ADDR_W'(OFS_PEND))   rd_val = WORD_W'(status_i & mask_i);
        for (int c = 0; c < NUM_CH; c++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (rd_addr_i == ADDR_W'(CS_BASE + c * CH_STRIDE + w * BYTES))
                    rd_val = cs_live_i[c][w*WORD_W +: WORD_W];
                if (rd_addr_i == ADDR_W'(CS_BASE + c * CH_STRIDE + UD_REL + w * BYTES))
                    rd_val = ud_live_i[c][w*WORD_W +: WORD_W];
            end
        end
    end

    // Register the read result on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= rd_val;
        end
    end

    assign rd_data_o = rd_q;

    // R11: the output only moves on a read strobe
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_q));
endmodule

// File: rtl/cs_user_capture.sv
// Top of the channel-status/user-bit capture block. Ties the bit
// collector to the event register and the read port, and places the
// collector's events at their interrupt bit positions next to the
// decoder's external events. Assumes one register access per cycle.
module cs_user_capture
    import csu_pkg::*;
#(
    parameter int FRAMES    = 192,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CS_BASE   = 'h30,
    parameter int CH_STRIDE = 'h30,
    parameter int UD_REL    = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_ch_i,
    input  logic              cs_bit_i,
    input  logic              ud_bit_i,
    input  logic              blk_start_i,
    input  logic [14:0]       ext_evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [14:0]       wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0][FRAMES-1:0] cs_live, ud_live;
    logic                          blk_end, blk_st;
    logic [NUM_CH-1:0]             csc;
    logic [IRQ_W-1:0]              evt, status, mask;

    csu_collect #(.FRAMES(FRAMES)) collect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (bit_vld_i),
        .bit_ch_i   (bit_ch_i),
        .cs_bit_i   (cs_bit_i),
        .ud_bit_i   (ud_bit_i),
        .blk_start_i(blk_start_i),
        .cs_live_o  (cs_live),
        .ud_live_o  (ud_live),
        .blk_end_o  (blk_end),
        .blk_st_o   (blk_st),
        .csc_o      (csc)
    );

    // Place collector events at their fixed bit positions beside the external ones.
    always_comb begin
        evt            = ext_evt_i & EXT_MASK;
        evt[IB_BLKEND] = blk_end;
        evt[IB_BLKST]  = blk_st;
        for (int c = 0; c < NUM_CH; c++) begin
            evt[IB_CSC0 + c] = csc[c];
        end
    end

    csu_irq #(.ADDR_W(ADDR_W)) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_en_i  (rd_en_i),
        .rd_addr_i(rd_addr_i),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    csu_rdport #(
        .FRAMES   (FRAMES),
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .CS_BASE  (CS_BASE),
        .CH_STRIDE(CH_STRIDE),
        .UD_REL   (UD_REL)
    ) rdport_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rd_en_i),
        .rd_addr_i(rd_addr_i),
        .status_i (status),
        .mask_i   (mask),
        .cs_live_i(cs_live),
        .ud_live_i(ud_live),
        .rd_data_o(rd_data_o)
    );

    // R4: a block end is never taken without a subframe strobe
    assert_end_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> (bit_vld_i && bit_ch_i));
endmodule

// File: tb/cs_user_capture_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module cs_user_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0, bit_ch = 1'b0, cs_bit = 1'b0, ud_bit = 1'b0, blk_start = 1'b0;
    logic [14:0] ext_evt = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [14:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_user_capture dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld), .bit_ch_i(bit_ch),
        .cs_bit_i(cs_bit), .ud_bit_i(ud_bit), .blk_start_i(blk_start),
        .ext_evt_i(ext_evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic patbit(int seed, int ch, int f);
        return ((f * 7 + ch * 13 + seed * 5) % 11) < 5;
    endfunction

    function automatic logic [31:0] exp_word(int seed, int ch, int w);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) r[b] = patbit(seed, ch, w * 32 + b);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [14:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic send_range(input int s0, input int s1, input int su,
                              input int first, input int last, input bit st);
        for (int f = first; f <= last; f++) begin
            @(negedge clk);
            bit_vld = 1'b1; bit_ch = 1'b0; blk_start = st && (f == first);
            cs_bit = patbit(s0, 0, f); ud_bit = patbit(su, 0, f);
            @(negedge clk);
            bit_ch = 1'b1; blk_start = 1'b0;
            cs_bit = patbit(s1, 1, f); ud_bit = patbit(su, 1, f);
        end
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic check_words(input int s0, input int s1, input int su, input string req);
        logic [31:0] d;
        for (int c = 0; c < 2; c++) begin
            for (int w = 0; w < 6; w++) begin
                rd(8'(48 + c * 48 + w * 4), d);
                chk(req, d, exp_word(c == 0 ? s0 : s1, c, w));
                rd(8'(72 + c * 48 + w * 4), d);
                chk(req, d, exp_word(su, c, w));
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R1 status", d, 0);
        rd(8'h04, d); chk("R1 mask", d, 0);
        rd(8'h10, d); chk("R1 pending", d, 0);
        rd(8'h30, d); chk("R1 cs word", d, 0);
        rd(8'h78, d); chk("R1 user word", d, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_presync();
        logic [31:0] d;
        send_range(1, 3, 2, 0, 191, 1'b0);
        rd(8'h00, d); chk("R7 no block end before start", d, 0);
        rd(8'h30, d); chk("R7 nothing captured", d, 0);
    endtask

    task automatic t_first_block();
        logic [31:0] d;
        wr(8'h08, 15'h7FFF);
        rd(8'h04, d); chk("R9 mask set", d, 32'h7FFF);
        send_range(1, 3, 2, 0, 99, 1'b1);
        rd(8'h00, d); chk("R6 start event only", d, 32'h0800);
        rd(8'h34, d); chk("R3 words held mid-block", d, 0);
        send_range(1, 3, 2, 100, 191, 1'b0);
        chk("R10 irq on pending", 32'(irq), 1);
        rd(8'h00, d); chk("R4 R5 end and both changes", d, 32'h0308);
        rd(8'h00, d); chk("R10 status cleared by read", d, 0);
        check_words(1, 3, 2, "R2 placement block 1");
    endtask

    task automatic t_same_status();
        logic [31:0] d;
        send_range(1, 3, 4, 0, 191, 1'b1);
        rd(8'h00, d); chk("R5 user change only, no status change", d, 32'h0808);
        check_words(1, 3, 4, "R2 user words updated");
    endtask

    task automatic t_one_channel();
        logic [31:0] d;
        send_range(1, 5, 4, 0, 191, 1'b1);
        rd(8'h00, d); chk("R5 only channel 1 changed", d, 32'h0A08);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        send_range(6, 7, 8, 0, 49, 1'b1);
        rd(8'h00, d); chk("R6 partial block no end", d, 32'h0800);
        check_words(1, 5, 4, "R6 R3 partial discarded");
        send_range(2, 5, 9, 0, 191, 1'b1);
        rd(8'h00, d); chk("R6 R5 restart then full block", d, 32'h0908);
        check_words(2, 5, 9, "R2 placement after restart");
    endtask

    task automatic t_external();
        logic [31:0] d;
        @(negedge clk); ext_evt = 15'h7FFF;
        @(negedge clk); ext_evt = '0;
        rd(8'h00, d); chk("R8 external positions", d, 32'h2067);
    endtask

    task automatic t_mask_pending();
        logic [31:0] d;
        wr(8'h0C, 15'h7FFE);
        rd(8'h04, d); chk("R9 mask clear", d, 32'h0001);
        @(negedge clk); ext_evt = 15'h0021;
        @(negedge clk); ext_evt = '0;
        rd(8'h10, d); chk("R10 pending masked", d, 32'h0001);
        rd(8'h10, d); chk("R10 pending read keeps status", d, 32'h0001);
        chk("R10 irq high", 32'(irq), 1);
        rd(8'h00, d); chk("R10 status raw", d, 32'h0021);
        chk("R10 irq low after clear", 32'(irq), 0);
        @(negedge clk); ext_evt = 15'h0020;
        @(negedge clk); ext_evt = '0;
        @(negedge clk); rd_en = 1'b1; rd_addr = 8'h00; ext_evt = 15'h0004;
        @(negedge clk); rd_en = 1'b0; ext_evt = '0;
        chk("R10 read during event returns old", rd_data, 32'h0020);
        rd(8'h00, d); chk("R10 same-cycle event survives", d, 32'h0004);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'h2C, d); chk("R11 gap offset", d, 0);
        rd(8'h31, d); chk("R11 misaligned", d, 0);
        rd(8'h90, d); chk("R11 beyond words", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_presync();
        t_first_block();
        t_same_status();
        t_one_channel();
        t_restart();
        t_external();
        t_mask_pending();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule